// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the integer arithmetic and logic stage of a load/store RISC pipeline. Each cycle it accepts two 32-bit operands, a 5-bit constant shift amount and a 5-bit operation code. One clock later it presents a registered 32-bit result, a flag that is high when that result is zero, and an exception flag that requests a trap.

The operations are:
- add and subtract, each in a trapping and a wrapping form;
- the four bitwise functions AND, OR, XOR and NOR;
- left logical, right logical and right arithmetic shifts, with the amount taken either from the constant field or from a register operand;
- signed and unsigned less-than compares that produce a 0 or 1 result;
- an upper-half constant load.

Only the trapping add and trapping subtract can raise the exception. Immediate forms such as add-immediate reuse the register forms, because the immediate is extended to 32 bits before it reaches the block. When an exception is flagged, the consumer must cancel the register write. The block still shows the wrapped sum or difference on its result output.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `result_o`=0, `zero_o`=1 and `ovf_o`=0.
- R2: Outputs are registered. Inputs sampled at one rising edge appear on the outputs after that edge and stay unchanged until the next edge.
- R3: Op 0 (trapping add, A+B) and op 2 (trapping subtract, A-B) set `ovf_o`. For add, this happens when A and B have the same sign and the result sign differs. For subtract, it happens when A and B differ in sign and the result sign differs from A.
- R4: Op 1 (wrapping add) and op 3 (wrapping subtract) never set `ovf_o`. Every add or subtract outputs the 32-bit wrapped value, including when `ovf_o` is set.
- R5: Ops 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT(A OR B), respectively.
- R6: Ops 8, 9 and 10 shift A left logical, right logical and right arithmetic by `shamt_i`. An amount of 0 returns A unchanged.
- R7: Ops 11, 12 and 13 are the same three shifts, with the amount taken from B[4:0]. B[31:5] has no effect.
- R8: Right arithmetic shifts fill the vacated upper bits with A[31]. Right logical shifts fill them with 0.
- R9: Op 14 gives 1 when A < B as two's complement numbers, and 0 otherwise. Op 15 does the same comparison as unsigned numbers.
- R10: Op 16 gives B[15:0] in bits 31:16 and zero in bits 15:0.
- R11: `zero_o` is high exactly when the 32-bit result is zero.
- R12: Op codes 17 to 31 give a result of 0 with `ovf_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | Operand A (also the shifted value) |
| b_i | input | 32 | Operand B (also variable shift amount and upper-load constant) |
| shamt_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Result equals zero |
| ovf_o | output | 1 | Signed overflow exception request |

## Verification
Sign-boundary operands are used first:
- 0x7FFFFFFF+1 and 0x80000000-1 separate overflow in the trapping forms from silence in the wrapping forms, and confirm the wrapped value.
- 0xFFFFFFFF against 1 makes the signed and unsigned compares disagree.
- A negative operand shifted right tells the sign fill apart from the zero fill.

A variable shift whose B operand has upper bits set shows whether only the low five bits set the amount. Seeded random operands and op codes, including unassigned codes, then run every operation across the full value range against a bench model. Operands that sum to zero exercise the zero flag.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  typedef enum logic [4:0] {
    OP_ADD_T = 5'd0,
    OP_ADD_W = 5'd1,
    OP_SUB_T = 5'd2,
    OP_SUB_W = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLL_K = 5'd8,
    OP_SRL_K = 5'd9,
    OP_SRA_K = 5'd10,
    OP_SLL_V = 5'd11,
    OP_SRL_V = 5'd12,
    OP_SRA_V = 5'd13,
    OP_SLT_S = 5'd14,
    OP_SLT_U = 5'd15,
    OP_LUI   = 5'd16
  } iexu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } iexu_shift_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } iexu_logic_e;

endpackage

// File: rtl/iexu_addsub.sv
module iexu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  end

  assign sum_o  = full[WIDTH-1:0];
  // same-sign inputs into the adder with a flipped result sign
  assign ovf_o  = (a_i[WIDTH-1] == b_eff[WIDTH-1]) &&
                  (full[WIDTH-1] != a_i[WIDTH-1]);
  // valid only with sub_i high: no carry out means a borrow
  assign lt_u_o = ~full[WIDTH];
  assign lt_s_o = full[WIDTH-1] ^ ovf_o;

endmodule

// File: rtl/iexu_logic.sv
module iexu_logic
  import iexu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  iexu_logic_e      fn_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/iexu_shift.sv
module iexu_shift
  import iexu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   d_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  iexu_shift_e        kind_i,
  output logic [WIDTH-1:0]   y_o
);

  logic [WIDTH-1:0] stage [SHAMT_W+1];
  logic             fill;

  assign fill     = (kind_i == SH_RARI) ? d_i[WIDTH-1] : 1'b0;
  assign stage[0] = d_i;

  // log-depth barrel: stage k moves the data by 2**k when amt bit k is set
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [WIDTH-1:0] moved;
    always_comb begin
      if (kind_i == SH_LEFT)
        moved = {stage[k][WIDTH-1-STEP:0], {STEP{1'b0}}};
      else
        moved = {{STEP{fill}}, stage[k][WIDTH-1:STEP]};
    end
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign y_o = stage[SHAMT_W];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4:0]         op_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [WIDTH-1:0]   result_o,
  output logic               zero_o,
  output logic               ovf_o
);

  localparam int HALF = WIDTH / 2;

  iexu_op_e         op;
  logic             use_sub;
  logic [WIDTH-1:0] as_sum;
  logic             as_ovf, as_lt_s, as_lt_u;
  logic [WIDTH-1:0] lg_y;
  iexu_logic_e      lg_fn;
  logic [WIDTH-1:0] sh_y;
  logic [SHAMT_W-1:0] sh_amt;
  iexu_shift_e      sh_kind;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_ovf;

  assign op = iexu_op_e'(op_i);

  always_comb begin
    use_sub = (op == OP_SUB_T) || (op == OP_SUB_W) ||
              (op == OP_SLT_S) || (op == OP_SLT_U);
    lg_fn   = iexu_logic_e'(op_i[1:0]);
    sh_amt  = ((op == OP_SLL_V) || (op == OP_SRL_V) || (op == OP_SRA_V))
              ? b_i[SHAMT_W-1:0] : shamt_i;
    unique case (op)
      OP_SRL_K, OP_SRL_V: sh_kind = SH_RLOG;
      OP_SRA_K, OP_SRA_V: sh_kind = SH_RARI;
      default:            sh_kind = SH_LEFT;
    endcase
  end

  iexu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (use_sub),
    .sum_o  (as_sum),
    .ovf_o  (as_ovf),
    .lt_s_o (as_lt_s),
    .lt_u_o (as_lt_u)
  );

  iexu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (lg_fn),
    .y_o  (lg_y)
  );

  iexu_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
    .d_i    (a_i),
    .amt_i  (sh_amt),
    .kind_i (sh_kind),
    .y_o    (sh_y)
  );

  always_comb begin
    nxt_res = '0;
    nxt_ovf = 1'b0;
    case (op)
      OP_ADD_T, OP_SUB_T: begin
        nxt_res = as_sum;
        nxt_ovf = as_ovf;
      end
      OP_ADD_W, OP_SUB_W:           nxt_res = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR: nxt_res = lg_y;
      OP_SLL_K, OP_SRL_K, OP_SRA_K,
      OP_SLL_V, OP_SRL_V, OP_SRA_V:  nxt_res = sh_y;
      OP_SLT_S: nxt_res = {{(WIDTH-1){1'b0}}, as_lt_s};
      OP_SLT_U: nxt_res = {{(WIDTH-1){1'b0}}, as_lt_u};
      OP_LUI:   nxt_res = {b_i[HALF-1:0], {HALF{1'b0}}};
      default: begin
        nxt_res = '0;
        nxt_ovf = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= nxt_res;
      zero_o   <= (nxt_res == '0);
      ovf_o    <= nxt_ovf;
    end
  end

endmodule

// File: rtl/int_exec_unit_checker.sv
module int_exec_unit_checker
  import iexu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input logic               clk,
  input logic               rst,
  input logic [4:0]         op_i,
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [WIDTH-1:0]   result_o,
  input logic               zero_o,
  input logic               ovf_o
);

  localparam int HALF = WIDTH / 2;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && zero_o && !ovf_o)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op_i) != OP_ADD_T && $past(op_i) != OP_SUB_T |-> !ovf_o); // R4

  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op_i) == OP_ADD_T |-> result_o == $past(a_i + b_i)); // R3

  AST_NOR_FN: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op_i) == OP_NOR |-> result_o == ~($past(a_i) | $past(b_i))); // R5

  AST_SRA_FILL: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op_i) == OP_SRA_K && $past(a_i[WIDTH-1]) |-> result_o[WIDTH-1]); // R8

  AST_SLT_BOOL: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(op_i) == OP_SLT_S || $past(op_i) == OP_SLT_U)
    |-> result_o[WIDTH-1:1] == '0); // R9

  AST_LUI_LOW: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op_i) == OP_LUI |-> result_o[HALF-1:0] == '0); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0)); // R11

  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op_i) > OP_LUI |-> (result_o == '0 && !ovf_o)); // R12

endmodule

bind int_exec_unit int_exec_unit_checker #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .shamt_i  (shamt_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [31:0] result;
  logic        zero, ovf;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .shamt_i  (sh),
    .result_o (result),
    .zero_o   (zero),
    .ovf_o    (ovf)
  );

  // reference: {ovf, result}
  function automatic logic [32:0] model(input logic [4:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    logic [31:0] r;
    logic        v;
    v = 1'b0;
    case (o)
      5'd0:  begin r = x + y; v = (x[31] == y[31]) && (r[31] != x[31]); end
      5'd1:  r = x + y;
      5'd2:  begin r = x - y; v = (x[31] != y[31]) && (r[31] != x[31]); end
      5'd3:  r = x - y;
      5'd4:  r = x & y;
      5'd5:  r = x | y;
      5'd6:  r = x ^ y;
      5'd7:  r = ~(x | y);
      5'd8:  r = x << s;
      5'd9:  r = x >> s;
      5'd10: r = $unsigned($signed(x) >>> s);
      5'd11: r = x << y[4:0];
      5'd12: r = x >> y[4:0];
      5'd13: r = $unsigned($signed(x) >>> y[4:0]);
      5'd14: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      5'd15: r = (x < y) ? 32'd1 : 32'd0;
      5'd16: r = {y[15:0], 16'h0000};
      default: r = 32'd0;
    endcase
    return {v, r};
  endfunction

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd2:          return "R3";
      5'd1, 5'd3:          return "R4";
      5'd4, 5'd5, 5'd6, 5'd7: return "R5";
      5'd8, 5'd9:          return "R6";
      5'd10, 5'd13:        return "R8";
      5'd11, 5'd12:        return "R7";
      5'd14, 5'd15:        return "R9";
      5'd16:               return "R10";
      default:             return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic ez,
                       input logic eo);
    n_checks++;
    if (result !== er || zero !== ez || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s: got res=%h zero=%b ovf=%b, expected res=%h zero=%b ovf=%b",
               tag, result, zero, ovf, er, ez, eo);
    end
  endtask

  // inputs set at a falling edge, captured at the next rising edge,
  // checked at the falling edge after that
  task automatic run(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] s, input string tag);
    logic [32:0] m;
    op = o; a = x; b = y; sh = s;
    m = model(o, x, y, s);
    @(negedge clk);
    check(tag, m[31:0], (m[31:0] == 32'd0), m[32]);
    if (m[31:0] == 32'd0) check("R11", m[31:0], 1'b1, m[32]);
  endtask

  initial begin
    int guard = 0;
    while (guard < 100000) begin
      @(posedge clk);
      guard++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ce5_0042));
    rst = 1'b1; op = 5'd0; a = 32'h1234_5678; b = 32'h1111_1111; sh = 5'd3;
    @(negedge clk); @(negedge clk);
    check("R1", 32'd0, 1'b1, 1'b0);
    rst = 1'b0;

    // R3 / R4 sign boundaries
    run(5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R3");
    run(5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R4");
    run(5'd2, 32'h8000_0000, 32'h0000_0001, 5'd0, "R3");
    run(5'd3, 32'h8000_0000, 32'h0000_0001, 5'd0, "R4");
    run(5'd2, 32'h0000_0005, 32'h0000_0007, 5'd0, "R3");
    run(5'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, "R3");
    run(5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R11");
    run(5'd7, 32'h0000_0000, 32'h0000_0000, 5'd0, "R5");
    run(5'd8, 32'hDEAD_BEEF, 32'h0, 5'd0, "R6");
    run(5'd10, 32'h8000_0000, 32'h0, 5'd31, "R8");
    run(5'd9, 32'h8000_0000, 32'h0, 5'd31, "R8");
    run(5'd12, 32'h8000_0000, 32'hFFFF_FFE4, 5'd0, "R7");
    run(5'd14, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R9");
    run(5'd15, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R9");
    run(5'd16, 32'hFFFF_FFFF, 32'h1234_ABCD, 5'd7, "R10");
    run(5'd31, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd1, "R12");

    // R2: a new operation is not visible before the capturing edge
    op = 5'd4; a = 32'hFFFF_0000; b = 32'h0F0F_0F0F; sh = 5'd0;
    #1;
    check("R2", 32'h0000_0000, 1'b1, 1'b0);
    @(negedge clk);
    check("R2", 32'h0F0F_0000, 1'b0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  ro;
      logic [31:0] ra, rb;
      ro = 5'($urandom_range(0, 20));
      ra = $urandom;
      rb = $urandom;
      if (i % 7 == 0) rb = -ra;
      if (i % 11 == 0) ra = {ra[31], 31'h7FFF_FFFF};
      run(ro, ra, rb, 5'($urandom), tag_of(ro));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule